// File: doc/BRIEF.md
# XGMII Dual-Mode Loopback Switch

This block sits on the 10-Gbps data path between an Ethernet MAC and a PHY. Each clock it carries one 64-bit data word and eight per-lane control bits in each direction. Two enable bits, held in a small memory-mapped register file, choose how the two streams are routed. With neither bit set, the block is a plain pass-through. In line mode, the stream received from the PHY is echoed to the PHY transmit side and is also handed to the MAC, while the MAC's transmit traffic is thrown away. In local mode, the MAC's transmit stream is turned back to the MAC receive side, and the PHY is fed continuous idle.

Every data-path output comes from a flop, so all routes share one cycle of latency and a mode change cannot glitch an output. Software reaches the enables through a synchronous bus with an address, write and read strobes, and 32-bit data. Read data appears one cycle after the read strobe.

Top module: `xgmii_loop_switch`

## Requirements
- R1: Reset state. During and after reset both enables read as 0. Both data outputs show XGMII idle: every data byte is 0x07 and all eight control bits are 1.
- R2: With both enables clear, the PHY transmit output equals the MAC transmit input, and the MAC receive output equals the PHY receive input. Both are delayed by exactly one clock, data and control alike.
- R3: With the line enable set, the PHY transmit output equals the PHY receive input of the previous clock, whatever the local enable is.
- R4: With only the line enable set, the MAC receive output equals the PHY receive input of the previous clock. The MAC transmit input has no effect on either output.
- R5: With only the local enable set, the MAC receive output equals the MAC transmit input of the previous clock. The PHY transmit output is idle (data bytes 0x07, control bits all 1).
- R6: With both enables set, the PHY transmit output follows the PHY receive input and the MAC receive output follows the MAC transmit input, each one clock later.
- R7: The line enable is bit 0 of byte address 0x00 and the local enable is bit 0 of byte address 0x08. A write loads wdata bit 0 into the bit. A read returns the bit in rdata bit 0, and bits 31..1 always read 0.
- R8: Address 0x04 is reserved, and so is every other address. A write there changes neither enable nor any output routing. A read there returns 0.
- R9: Read data is registered. A read strobe at one clock edge shows its value after that edge. In any cycle following an edge without a read strobe, rdata is 0.
- R10: A write sampled at clock edge k already selects the route for the data word registered at edge k+1. The word registered at edge k still uses the previous mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the data path and registers |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_addr | input | 8 | Register byte address |
| cfg_wr | input | 1 | Register write strobe |
| cfg_rd | input | 1 | Register read strobe |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data, one cycle after cfg_rd |
| mac_tx_d | input | 64 | Data from MAC transmit |
| mac_tx_c | input | 8 | Per-lane control from MAC transmit |
| phy_rx_d | input | 64 | Data received from PHY |
| phy_rx_c | input | 8 | Per-lane control received from PHY |
| phy_tx_d | output | 64 | Data toward PHY transmit |
| phy_tx_c | output | 8 | Per-lane control toward PHY transmit |
| mac_rx_d | output | 64 | Data toward MAC receive |
| mac_rx_c | output | 8 | Per-lane control toward MAC receive |

## Verification
The bound checker compares every cycle against the enable state of the previous cycle:
- the PHY transmit and MAC receive outputs against the registered inputs of each route;
- the idle pattern in local mode;
- the zero upper bits of read data;
- a zero rdata after any cycle without a read or with a read of the reserved word.

Only the bench's scenarios can show the rest:
- the register map as software sees it;
- that a write to a reserved address leaves routing untouched;
- the exact edge at which a mode change lands between two data words;
- that MAC transmit data never leaks out in line mode.

// File: rtl/lpbk_pkg.sv
package lpbk_pkg;
    localparam int unsigned REG_W     = 32;
    localparam int unsigned LANE_W    = 8;
    localparam logic [7:0]  IDLE_CHAR = 8'h07;

    // byte offsets of the control words
    localparam int unsigned OFS_LINE  = 'h00;
    localparam int unsigned OFS_RSVD  = 'h04;
    localparam int unsigned OFS_LOCAL = 'h08;

    typedef struct packed {
        logic             line_en;
        logic             local_en;
        logic [REG_W-1:0] rdata;
    } cfg_state_t;
endpackage

// File: rtl/lpbk_regs.sv
module lpbk_regs
    import lpbk_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic              cfg_wr,
    input  logic              cfg_rd,
    input  logic [REG_W-1:0]  cfg_wdata,
    output logic [REG_W-1:0]  cfg_rdata,
    output logic              line_en,
    output logic              local_en
);
    localparam logic [ADDR_W-1:0] A_LINE  = ADDR_W'(OFS_LINE);
    localparam logic [ADDR_W-1:0] A_LOCAL = ADDR_W'(OFS_LOCAL);

    cfg_state_t s_d, s_q;

    logic unused_wbits;
    assign unused_wbits = &{1'b0, cfg_wdata[REG_W-1:1]};

    always_comb begin
        s_d       = s_q;
        s_d.rdata = '0;
        if (cfg_wr) begin
            if (cfg_addr == A_LINE)  s_d.line_en  = cfg_wdata[0];
            if (cfg_addr == A_LOCAL) s_d.local_en = cfg_wdata[0];
        end
        if (cfg_rd) begin
            if (cfg_addr == A_LINE)  s_d.rdata = {{(REG_W-1){1'b0}}, s_q.line_en};
            if (cfg_addr == A_LOCAL) s_d.rdata = {{(REG_W-1){1'b0}}, s_q.local_en};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cfg_rdata = s_q.rdata;
    assign line_en   = s_q.line_en;
    assign local_en  = s_q.local_en;
endmodule

// File: rtl/lpbk_route.sv
module lpbk_route
    import lpbk_pkg::*;
#(
    parameter int unsigned DATA_W = 64
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     line_en,
    input  logic                     local_en,
    input  logic [DATA_W-1:0]        mac_tx_d,
    input  logic [DATA_W/LANE_W-1:0] mac_tx_c,
    input  logic [DATA_W-1:0]        phy_rx_d,
    input  logic [DATA_W/LANE_W-1:0] phy_rx_c,
    output logic [DATA_W-1:0]        phy_tx_d,
    output logic [DATA_W/LANE_W-1:0] phy_tx_c,
    output logic [DATA_W-1:0]        mac_rx_d,
    output logic [DATA_W/LANE_W-1:0] mac_rx_c
);
    localparam int unsigned CTRL_W = DATA_W / LANE_W;

    typedef struct packed {
        logic [DATA_W-1:0] ptx_d;
        logic [CTRL_W-1:0] ptx_c;
        logic [DATA_W-1:0] mrx_d;
        logic [CTRL_W-1:0] mrx_c;
    } path_t;

    logic [DATA_W-1:0] idle_d;
    path_t p_d, p_q, p_rst;

    // one idle character per lane
    for (genvar g = 0; g < CTRL_W; g++) begin : g_idle
        assign idle_d[g*LANE_W +: LANE_W] = IDLE_CHAR;
    end

    assign p_rst = '{ptx_d: idle_d, ptx_c: '1, mrx_d: idle_d, mrx_c: '1};

    always_comb begin
        // PHY transmit: line wins, then local idles, else MAC transmit
        if (line_en) begin
            p_d.ptx_d = phy_rx_d;
            p_d.ptx_c = phy_rx_c;
        end else if (local_en) begin
            p_d.ptx_d = idle_d;
            p_d.ptx_c = '1;
        end else begin
            p_d.ptx_d = mac_tx_d;
            p_d.ptx_c = mac_tx_c;
        end
        // MAC receive: local turns MAC transmit around, else PHY receive
        if (local_en) begin
            p_d.mrx_d = mac_tx_d;
            p_d.mrx_c = mac_tx_c;
        end else begin
            p_d.mrx_d = phy_rx_d;
            p_d.mrx_c = phy_rx_c;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) p_q <= p_rst;
        else        p_q <= p_d;
    end

    assign phy_tx_d = p_q.ptx_d;
    assign phy_tx_c = p_q.ptx_c;
    assign mac_rx_d = p_q.mrx_d;
    assign mac_rx_c = p_q.mrx_c;
endmodule

// File: rtl/xgmii_loop_switch.sv
module xgmii_loop_switch
    import lpbk_pkg::*;
#(
    parameter int unsigned DATA_W = 64,
    parameter int unsigned ADDR_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ADDR_W-1:0]        cfg_addr,
    input  logic                     cfg_wr,
    input  logic                     cfg_rd,
    input  logic [REG_W-1:0]         cfg_wdata,
    output logic [REG_W-1:0]         cfg_rdata,
    input  logic [DATA_W-1:0]        mac_tx_d,
    input  logic [DATA_W/LANE_W-1:0] mac_tx_c,
    input  logic [DATA_W-1:0]        phy_rx_d,
    input  logic [DATA_W/LANE_W-1:0] phy_rx_c,
    output logic [DATA_W-1:0]        phy_tx_d,
    output logic [DATA_W/LANE_W-1:0] phy_tx_c,
    output logic [DATA_W-1:0]        mac_rx_d,
    output logic [DATA_W/LANE_W-1:0] mac_rx_c
);
    logic line_en;
    logic local_en;

    lpbk_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_addr (cfg_addr),
        .cfg_wr   (cfg_wr),
        .cfg_rd   (cfg_rd),
        .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata),
        .line_en  (line_en),
        .local_en (local_en)
    );

    lpbk_route #(.DATA_W(DATA_W)) u_route (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_en  (line_en),
        .local_en (local_en),
        .mac_tx_d (mac_tx_d),
        .mac_tx_c (mac_tx_c),
        .phy_rx_d (phy_rx_d),
        .phy_rx_c (phy_rx_c),
        .phy_tx_d (phy_tx_d),
        .phy_tx_c (phy_tx_c),
        .mac_rx_d (mac_rx_d),
        .mac_rx_c (mac_rx_c)
    );
endmodule

// File: rtl/lpbk_chk.sv
module lpbk_chk
    import lpbk_pkg::*;
#(
    parameter int unsigned DATA_W = 64,
    parameter int unsigned ADDR_W = 8
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     line_en,
    input logic                     local_en,
    input logic [ADDR_W-1:0]        cfg_addr,
    input logic                     cfg_rd,
    input logic [REG_W-1:0]         cfg_rdata,
    input logic [DATA_W-1:0]        mac_tx_d,
    input logic [DATA_W/LANE_W-1:0] mac_tx_c,
    input logic [DATA_W-1:0]        phy_rx_d,
    input logic [DATA_W/LANE_W-1:0] phy_rx_c,
    input logic [DATA_W-1:0]        phy_tx_d,
    input logic [DATA_W/LANE_W-1:0] phy_tx_c,
    input logic [DATA_W-1:0]        mac_rx_d,
    input logic [DATA_W/LANE_W-1:0] mac_rx_c
);
    localparam logic [ADDR_W-1:0] A_RSVD = ADDR_W'(OFS_RSVD);

    // R2
    pass_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!line_en && !local_en) |=> (phy_tx_d == $past(mac_tx_d) && phy_tx_c == $past(mac_tx_c)
                                     && mac_rx_d == $past(phy_rx_d) && mac_rx_c == $past(phy_rx_c)));

    // R3
    line_echo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        line_en |=> (phy_tx_d == $past(phy_rx_d) && phy_tx_c == $past(phy_rx_c)));

    // R4
    line_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (line_en && !local_en) |=> (mac_rx_d == $past(phy_rx_d) && mac_rx_c == $past(phy_rx_c)));

    // R5
    local_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (local_en && !line_en) |=> (phy_tx_d == {(DATA_W/LANE_W){IDLE_CHAR}} && &phy_tx_c));

    // R6
    local_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        local_en |=> (mac_rx_d == $past(mac_tx_d) && mac_rx_c == $past(mac_tx_c)));

    // R7
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rdata[REG_W-1:1] == '0);

    // R8
    rsvd_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rd && cfg_addr == A_RSVD) |=> cfg_rdata == '0);

    // R9
    idle_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_rd |=> cfg_rdata == '0);
endmodule

bind xgmii_loop_switch lpbk_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .line_en  (line_en),
    .local_en (local_en),
    .cfg_addr (cfg_addr),
    .cfg_rd   (cfg_rd),
    .cfg_rdata(cfg_rdata),
    .mac_tx_d (mac_tx_d),
    .mac_tx_c (mac_tx_c),
    .phy_rx_d (phy_rx_d),
    .phy_rx_c (phy_rx_c),
    .phy_tx_d (phy_tx_d),
    .phy_tx_c (phy_tx_c),
    .mac_rx_d (mac_rx_d),
    .mac_rx_c (mac_rx_c)
);

// File: tb/sim_xgmii_loop_switch.sv
module sim_xgmii_loop_switch;
    localparam int CLK_PERIOD = 10;
    localparam logic [63:0] IDLE_D = {8{8'h07}};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic        cfg_wr = 1'b0;
    logic        cfg_rd = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic [63:0] mac_tx_d = '0;
    logic [7:0]  mac_tx_c = '0;
    logic [63:0] phy_rx_d = '0;
    logic [7:0]  phy_rx_c = '0;
    logic [63:0] phy_tx_d;
    logic [7:0]  phy_tx_c;
    logic [63:0] mac_rx_d;
    logic [7:0]  mac_rx_c;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xgmii_loop_switch u0 (
        .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .mac_tx_d(mac_tx_d), .mac_tx_c(mac_tx_c), .phy_rx_d(phy_rx_d), .phy_rx_c(phy_rx_c),
        .phy_tx_d(phy_tx_d), .phy_tx_c(phy_tx_c), .mac_rx_d(mac_rx_d), .mac_rx_c(mac_rx_c)
    );

    task automatic check(input string req, input logic [71:0] act, input logic [71:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [7:0] a, input logic [31:0] v);
        @(negedge clk);
        cfg_addr = a; cfg_wdata = v; cfg_wr = 1'b1;
        @(posedge clk); #1;
        cfg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [7:0] a, output logic [31:0] v);
        @(negedge clk);
        cfg_addr = a; cfg_rd = 1'b1;
        @(posedge clk); #1;
        cfg_rd = 1'b0;
        v = cfg_rdata;
    endtask

    // drive one word each way, check both outputs one edge later
    task automatic xfer(input string req, input logic [71:0] mtx, input logic [71:0] prx,
                        input logic [71:0] exp_ptx, input logic [71:0] exp_mrx);
        @(negedge clk);
        {mac_tx_d, mac_tx_c} = mtx;
        {phy_rx_d, phy_rx_c} = prx;
        @(posedge clk); #1;
        check({req, " phy_tx"}, {phy_tx_d, phy_tx_c}, exp_ptx);
        check({req, " mac_rx"}, {mac_rx_d, mac_rx_c}, exp_mrx);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        @(negedge clk);
        check("R1 reset phy_tx", {phy_tx_d, phy_tx_c}, {IDLE_D, 8'hFF});
        check("R1 reset mac_rx", {mac_rx_d, mac_rx_c}, {IDLE_D, 8'hFF});
        rst_n = 1'b1;
        reg_read(8'h00, v); check("R1 line reads 0", {40'd0, v}, 72'd0);
        reg_read(8'h08, v); check("R1 local reads 0", {40'd0, v}, 72'd0);
    endtask

    task automatic t_pass();
        logic [71:0] a = {64'h1122_3344_5566_7788, 8'h01};
        logic [71:0] b = {64'hA5A5_0F0F_F0F0_5A5A, 8'h80};
        xfer("R2 pass p1", a, b, a, b);
        xfer("R2 pass p2", b, a, b, a);
    endtask

    task automatic t_line();
        logic [71:0] m = {64'hDEAD_BEEF_0000_0001, 8'h0F};
        logic [71:0] p = {64'h0102_0304_0506_0708, 8'hF0};
        reg_write(8'h00, 32'h1);
        xfer("R3 R4 line", m, p, p, p);
        xfer("R4 line mac ignored", ~m, ~p, ~p, ~p);
        reg_write(8'h00, 32'h0);
    endtask

    task automatic t_local();
        logic [71:0] m = {64'hCAFE_F00D_1234_5678, 8'h3C};
        logic [71:0] p = {64'h9999_AAAA_BBBB_CCCC, 8'h00};
        reg_write(8'h08, 32'h1);
        xfer("R5 local", m, p, {IDLE_D, 8'hFF}, m);
        xfer("R5 local p2", p, m, {IDLE_D, 8'hFF}, p);
        reg_write(8'h08, 32'h0);
    endtask

    task automatic t_both();
        logic [71:0] m = {64'h0F1E_2D3C_4B5A_6978, 8'hAA};
        logic [71:0] p = {64'h8796_A5B4_C3D2_E1F0, 8'h55};
        reg_write(8'h00, 32'h1);
        reg_write(8'h08, 32'h1);
        xfer("R6 both", m, p, p, m);
        reg_write(8'h00, 32'h0);
        reg_write(8'h08, 32'h0);
    endtask

    task automatic t_regmap();
        logic [31:0] v;
        logic [71:0] m = {64'h7777_6666_5555_4444, 8'h12};
        logic [71:0] p = {64'h3333_2222_1111_0000, 8'h34};
        reg_write(8'h00, 32'hFFFF_FFFF);
        reg_read(8'h00, v); check("R7 line bit0 set, upper 0", {40'd0, v}, 72'd1);
        reg_write(8'h00, 32'hFFFF_FFFE);
        reg_read(8'h00, v); check("R7 line cleared by bit0=0", {40'd0, v}, 72'd0);
        reg_write(8'h08, 32'h0000_0003);
        reg_read(8'h08, v); check("R7 local bit0 set", {40'd0, v}, 72'd1);
        reg_write(8'h08, 32'h0);
        reg_write(8'h04, 32'hFFFF_FFFF);
        reg_write(8'h0C, 32'hFFFF_FFFF);
        reg_read(8'h04, v); check("R8 reserved reads 0", {40'd0, v}, 72'd0);
        reg_read(8'h00, v); check("R8 line untouched", {40'd0, v}, 72'd0);
        reg_read(8'h08, v); check("R8 local untouched", {40'd0, v}, 72'd0);
        xfer("R8 routing still pass", m, p, m, p);
    endtask

    task automatic t_rdtiming();
        logic [31:0] v;
        reg_write(8'h08, 32'h1);
        reg_read(8'h08, v); check("R9 read after one edge", {40'd0, v}, 72'd1);
        @(posedge clk); #1;
        check("R9 rdata zero without read", {40'd0, cfg_rdata}, 72'd0);
        reg_write(8'h08, 32'h0);
    endtask

    task automatic t_switch();
        logic [71:0] m1 = {64'h1010_1010_2020_2020, 8'h01};
        logic [71:0] p1 = {64'h3030_3030_4040_4040, 8'h02};
        logic [71:0] m2 = {64'h5050_5050_6060_6060, 8'h04};
        logic [71:0] p2 = {64'h7070_7070_8080_8080, 8'h08};
        // write and first word share edge k: old mode (pass) applies
        @(negedge clk);
        cfg_addr = 8'h00; cfg_wdata = 32'h1; cfg_wr = 1'b1;
        {mac_tx_d, mac_tx_c} = m1; {phy_rx_d, phy_rx_c} = p1;
        @(posedge clk); #1;
        cfg_wr = 1'b0;
        check("R10 edge k old mode", {phy_tx_d, phy_tx_c}, m1);
        xfer("R10 edge k+1 new mode", m2, p2, p2, p2);
        reg_write(8'h00, 32'h0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        t_pass();
        t_line();
        t_local();
        t_both();
        t_regmap();
        t_rdtiming();
        t_switch();
        t_pass();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end
endmodule